// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block sits between a set of interrupt request lines and the instruction fetch unit of a small processor. Each of its request lines has a fixed priority equal to its index. In every cycle it keeps the requests that are allowed to fire, picks the one with the highest index, and presents the 16-bit address of the vector word to fetch. The vector table sits at the top of the address space and is two bytes per entry, so the address follows from the index alone.

Line 31 is the reset line and cannot be blocked. A few lines are non-maskable: only their own enable can block them. The other used lines also need the global enable. Lines 0 to 15 have no source. The selection is registered. It is held while the fetch unit has not acknowledged it, and it is taken again on the clock edge where the acknowledge is high. Two further conditions are combinational. An instruction fetch into the low peripheral register region raises a reset request and forces the reset vector at once. If the reset vector is presented while its stored word is still erased (all ones), the block asks the core to go to sleep instead of running code.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among the allowed requests, the registered selection is the one with the highest index.
- R2: While the output is valid, vec_addr_o equals 0xFFC0 + 2 × vec_idx_o (index 31 gives 0xFFFE, index 16 gives 0xFFE0). While it is not valid, vec_addr_o and vec_idx_o are zero.
- R3: A maskable line (indices 16 to 28) is allowed only when its own enable bit and gie_i are both 1.
- R4: A non-maskable line (indices 29 and 30) is allowed when its own enable bit is 1, whatever gie_i is.
- R5: Line 31 (reset) is allowed whenever it is requested, whatever its enable bit and gie_i are.
- R6: Requests on lines 0 to 15 are never selected, whatever the enables are.
- R7: While a valid selection is shown and ack_i is low, the selection does not change. At a clock edge with ack_i high, or with no valid selection, the selection is loaded from the current requests and shows in the next cycle.
- R8: When fetch_vld_i is 1 and fetch_addr_i is below 0x0200, reset_req_o is 1 in the same cycle, and the outputs show index 31 at 0xFFFE as valid. A fetch at 0x0200 or above raises no reset request.
- R9: sleep_o is 1 exactly when the output shows index 31 as valid and boot_word_i is 0xFFFF.
- R10: After reset, and before any edge loads a request, vec_vld_o, vec_idx_o, vec_addr_o, reset_req_o and sleep_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 32 | Request lines; the index is the priority |
| irq_en_i | input | 32 | Enable bit for each line |
| gie_i | input | 1 | Global enable for maskable lines |
| ack_i | input | 1 | Fetch unit has taken the shown vector |
| fetch_vld_i | input | 1 | An instruction fetch is in progress |
| fetch_addr_i | input | 16 | Address of that fetch |
| boot_word_i | input | 16 | Word stored at the reset vector |
| vec_vld_o | output | 1 | A vector is shown |
| vec_addr_o | output | 16 | Address of the vector word |
| vec_idx_o | output | 5 | Index of the shown source |
| reset_req_o | output | 1 | Reset request from an illegal fetch |
| sleep_o | output | 1 | Erased reset vector shown; enter sleep |

## Verification
The held selection and the illegal-fetch override can occur in the same cycle. A selection is held with ack_i low, and a fetch below 0x0200 is then driven. The outputs must jump to the reset vector in that same cycle and return to the held index once the fetch ends. The random phase also mixes non-maskable and maskable requests with gie_i toggling and a random acknowledge. Every cycle is compared against a reference model in the bench that has its own registered selection.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned          N_SRC     = 32,
  parameter logic [N_SRC-1:0]     NMI_MASK  = 32'h6000_0000,
  parameter logic [N_SRC-1:0]     USED_MASK = 32'hFFFF_0000
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             gie_i,
  output logic [N_SRC-1:0] allowed_o
);
  localparam logic [N_SRC-1:0] RST_BIT = {1'b1, {(N_SRC-1){1'b0}}};

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    assign allowed_o[g] = req_i[g] & USED_MASK[g] &
                          (RST_BIT[g] | (en_i[g] & (NMI_MASK[g] | gie_i)));
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] allowed_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // ascending scan: last hit is the highest index
    for (int i = 0; i < N_SRC; i++) begin
      if (allowed_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_fetch_guard.sv
module irq_fetch_guard
  import irq_vec_pkg::*;
#(
  parameter addr_t LOW_LIMIT = 16'h0200
) (
  input  logic  fetch_vld_i,
  input  addr_t fetch_addr_i,
  output logic  illegal_o
);
  assign illegal_o = fetch_vld_i && (fetch_addr_i < LOW_LIMIT);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned      N_SRC     = 32,
  parameter logic [N_SRC-1:0] NMI_MASK  = 32'h6000_0000,
  parameter logic [N_SRC-1:0] USED_MASK = 32'hFFFF_0000,
  parameter addr_t            VEC_TOP   = 16'hFFFE,
  parameter addr_t            LOW_LIMIT = 16'h0200,
  parameter addr_t            ERASED    = 16'hFFFF,
  localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] boot_word_i,
  output logic              vec_vld_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic              reset_req_o,
  output logic              sleep_o
);
  localparam logic [IDX_W-1:0] RST_IDX  = IDX_W'(N_SRC-1);
  localparam addr_t            VEC_BASE = VEC_TOP - addr_t'(2*(N_SRC-1));

  logic [N_SRC-1:0] allowed;
  logic             any_hit;
  logic [IDX_W-1:0] pick_idx;
  logic             illegal;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic             out_vld;
  logic [IDX_W-1:0] out_idx;

  irq_gate #(.N_SRC(N_SRC), .NMI_MASK(NMI_MASK), .USED_MASK(USED_MASK)) u_gate (
    .req_i(irq_req_i), .en_i(irq_en_i), .gie_i(gie_i), .allowed_o(allowed)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .allowed_i(allowed), .any_o(any_hit), .idx_o(pick_idx)
  );

  irq_fetch_guard #(.LOW_LIMIT(LOW_LIMIT)) u_guard (
    .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i), .illegal_o(illegal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (!vld_q || ack_i) begin
      vld_q <= any_hit;
      idx_q <= any_hit ? pick_idx : '0;
    end
  end

  // illegal fetch overrides the held selection combinationally
  assign out_vld     = illegal | vld_q;
  assign out_idx     = illegal ? RST_IDX : idx_q;
  assign vec_vld_o   = out_vld;
  assign vec_idx_o   = out_idx;
  assign vec_addr_o  = out_vld ? VEC_BASE + (addr_t'(out_idx) << 1) : '0;
  assign reset_req_o = illegal;
  assign sleep_o     = out_vld && (out_idx == RST_IDX) && (boot_word_i == ERASED);

  a_r1_highest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (allowed[pick_idx] && ((allowed >> pick_idx) >> 1) == '0));

  a_r3_gie_blocks_maskable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> ((allowed & ~NMI_MASK & ~(N_SRC'(1) << (N_SRC-1))) == '0));

  a_r6_unused_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allowed & ~USED_MASK) == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !ack_i) |=> (vld_q && $stable(idx_q)));

  a_r8_fetch_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && fetch_addr_i < LOW_LIMIT) |-> (reset_req_o && vec_vld_o && vec_addr_o == VEC_TOP));

  a_r9_sleep_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (vec_vld_o && vec_addr_o == VEC_TOP && boot_word_i == ERASED));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_req_i = '0, irq_en_i = '0;
  logic        gie_i = 1'b0, ack_i = 1'b0, fetch_vld_i = 1'b0;
  logic [15:0] fetch_addr_i = 16'h0000, boot_word_i = 16'h0000;
  logic        vec_vld_o, reset_req_o, sleep_o;
  logic [15:0] vec_addr_o;
  logic [4:0]  vec_idx_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic m_vld = 1'b0;
  logic [4:0] m_idx = '0;

  irq_vector_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] allowed_f(logic [31:0] rq, logic [31:0] en, logic g);
    logic [31:0] a = '0;
    for (int i = 16; i < 32; i++) begin
      if (i == 31)                a[i] = rq[i];
      else if (i == 29 || i == 30) a[i] = rq[i] & en[i];
      else                        a[i] = rq[i] & en[i] & g;
    end
    return a;
  endfunction

  function automatic int top_f(logic [31:0] a);
    int t = -1;
    for (int i = 0; i < 32; i++) if (a[i]) t = i;
    return t;
  endfunction

  // reference model of the registered selection
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_vld <= 1'b0; m_idx <= '0;
    end else if (!m_vld || ack_i) begin
      int t;
      t = top_f(allowed_f(irq_req_i, irq_en_i, gie_i));
      m_vld <= (t >= 0);
      m_idx <= (t >= 0) ? 5'(t) : 5'd0;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic ill, ev, sl;
    logic [4:0] ei;
    logic [15:0] ea;
    ill = fetch_vld_i && fetch_addr_i < 16'h0200;
    ev  = ill | m_vld;
    ei  = ill ? 5'd31 : m_idx;
    ea  = ev ? 16'hFFC0 + 16'(ei) * 16'd2 : 16'h0000;
    sl  = ev && ei == 5'd31 && boot_word_i == 16'hFFFF;
    chk({tag, " vld"}, 32'(vec_vld_o), 32'(ev));
    chk({tag, " idx"}, 32'(vec_idx_o), 32'(ei));
    chk("R2 addr", 32'(vec_addr_o), 32'(ea));
    chk("R8 reset_req", 32'(reset_req_o), 32'(ill));
    chk("R9 sleep", 32'(sleep_o), 32'(sl));
  endtask

  // drive after a falling edge, compare once settled
  task automatic step(string tag, logic [31:0] rq, logic [31:0] en, logic g, logic ak,
                      logic fv, logic [15:0] fa, logic [15:0] bw);
    @(negedge clk_i);
    irq_req_i = rq; irq_en_i = en; gie_i = g; ack_i = ak;
    fetch_vld_i = fv; fetch_addr_i = fa; boot_word_i = bw;
    #1 compare(tag);
  endtask

  task automatic expect_idx(string tag, logic v, logic [4:0] i);
    chk({tag, " directed vld"}, 32'(vec_vld_o), 32'(v));
    chk({tag, " directed idx"}, 32'(vec_idx_o), 32'(i));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk("R10 vld", 32'(vec_vld_o), 0);
    chk("R10 addr", 32'(vec_addr_o), 0);
    chk("R10 reset_req", 32'(reset_req_o), 0);
    chk("R10 sleep", 32'(sleep_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step("R10", '0, '0, 0, 1, 0, 16'h8000, 16'h0000);

    // R1: 20 and 25 pending, 25 wins
    step("R1", 32'h0210_0000, '1, 1, 1, 0, 16'h8000, 0);
    step("R1", 32'h0210_0000, '1, 1, 1, 0, 16'h8000, 0);
    expect_idx("R1", 1, 5'd25);
    // R2: line 16 alone
    step("R2", 32'h0001_0000, '1, 1, 1, 0, 16'h8000, 0);
    step("R2", 32'h0001_0000, '1, 1, 1, 0, 16'h8000, 0);
    chk("R2 addr 16", 32'(vec_addr_o), 32'hFFE0);
    // R3: maskable blocked by gie, then by its own enable
    step("R3", 32'h0800_0000, '1, 0, 1, 0, 16'h8000, 0);
    step("R3", 32'h0800_0000, '1, 0, 1, 0, 16'h8000, 0);
    expect_idx("R3", 0, 5'd0);
    step("R3", 32'h0800_0000, 32'hF7FF_FFFF, 1, 1, 0, 16'h8000, 0);
    step("R3", 32'h0800_0000, 32'hF7FF_FFFF, 1, 1, 0, 16'h8000, 0);
    expect_idx("R3", 0, 5'd0);
    // R4: non-maskable ignores gie, blocked by own enable
    step("R4", 32'h4800_0000, 32'h4800_0000, 0, 1, 0, 16'h8000, 0);
    step("R4", 32'h4800_0000, 32'h4800_0000, 0, 1, 0, 16'h8000, 0);
    expect_idx("R4", 1, 5'd30);
    step("R4", 32'h4000_0000, 32'h0000_0000, 1, 1, 0, 16'h8000, 0);
    step("R4", 32'h4000_0000, 32'h0000_0000, 1, 1, 0, 16'h8000, 0);
    expect_idx("R4", 0, 5'd0);
    // R5 and R9: reset line with no enables, erased and programmed boot word
    step("R5", 32'h8000_0000, '0, 0, 1, 0, 16'h8000, 16'h1234);
    step("R5", 32'h8000_0000, '0, 0, 1, 0, 16'h8000, 16'h1234);
    expect_idx("R5", 1, 5'd31);
    chk("R9 programmed", 32'(sleep_o), 0);
    step("R9", 32'h8000_0000, '0, 0, 1, 0, 16'h8000, 16'hFFFF);
    chk("R9 erased", 32'(sleep_o), 1);
    // R6: low lines never chosen
    step("R6", 32'h0000_FFFF, '1, 1, 1, 0, 16'h8000, 0);
    step("R6", 32'h0000_FFFF, '1, 1, 1, 0, 16'h8000, 0);
    expect_idx("R6", 0, 5'd0);
    // R7: hold 20 while ack low, then 28 arrives
    step("R7", 32'h0010_0000, '1, 1, 0, 0, 16'h8000, 0);
    step("R7", 32'h1010_0000, '1, 1, 0, 0, 16'h8000, 0);
    step("R7", 32'h1010_0000, '1, 1, 0, 0, 16'h8000, 0);
    expect_idx("R7 held", 1, 5'd20);
    // R8 together with a held selection
    step("R8", 32'h1010_0000, '1, 1, 0, 1, 16'h01FF, 16'hFFFF);
    chk("R8 low fetch", 32'(reset_req_o), 1);
    chk("R8 forced addr", 32'(vec_addr_o), 32'hFFFE);
    step("R8", 32'h1010_0000, '1, 1, 0, 1, 16'h0200, 0);
    chk("R8 boundary", 32'(reset_req_o), 0);
    expect_idx("R7 after fetch", 1, 5'd20);
    step("R7", 32'h1000_0000, '1, 1, 1, 0, 16'h8000, 0);
    step("R7", 32'h1000_0000, '1, 1, 1, 0, 16'h8000, 0);
    expect_idx("R7 reload", 1, 5'd28);

    // random phase
    for (int k = 0; k < 600; k++) begin
      logic [31:0] rq, en;
      logic fv;
      logic [15:0] fa, bw;
      rq = $urandom() & $urandom();
      en = $urandom() | $urandom();
      fv = ($urandom_range(0, 7) == 0);
      fa = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 16'h03FF)) : 16'($urandom());
      bw = ($urandom_range(0, 1) == 0) ? 16'hFFFF : 16'($urandom());
      step("R1", rq, en, 1'($urandom()), 1'($urandom()), fv, fa, bw);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule